// File: doc/BRIEF.md
# Address-Based Security Attribution Unit

This block tags every bus transaction with a security attribute (secure, nonsecure-callable or nonsecure) using nothing but the transaction's target address. It has two lookup ports that use the same tables. One serves data accesses and the other serves instruction fetches. Each port gives its attribute in the same cycle as the address. The processor's security state is taken from the attribute of the code being fetched and is held in a register.

The attribute comes from two sources. The first is a set of programmable address regions. The second is a fixed default map that decodes a secure and a nonsecure alias for each of the flash, SRAM and peripheral windows. The final result is always the more secure of the two, so the regions can never weaken what the default map asks for. Secure firmware programs the regions through a small register port. It may do so once at boot or at any later time. Accesses to that port from the nonsecure side are refused and recorded in a sticky flag.

Top module: `sec_attr_unit`

## Requirements
- R1: Attribute outputs use the encoding nonsecure = 2'b00, nonsecure-callable = 2'b01, secure = 2'b10, so a larger value means more secure.
- R2: Default map: when addr[31:29] is 0 (flash), 1 (SRAM) or 2 (peripherals), the default is secure if addr[28] is 1 and nonsecure if addr[28] is 0. Every other address defaults to nonsecure.
- R3: There are 8 regions. Each has a base register and a limit register. Both keep only bits [31:5]. The limit register also holds an enable in bit 0 and a nonsecure-callable flag in bit 1. A region matches when it is enabled and base[31:5] <= addr[31:5] <= limit[31:5]. One match gives nonsecure-callable if the flag is set, and nonsecure otherwise.
- R4: Bit 0 of the control register is the global region enable. When it is 0, the programmable result is secure for every address.
- R5: If no enabled region matches, or two or more enabled regions match, the programmable result is secure.
- R6: The final attribute is the more secure of the programmable result and the default map.
- R7: The data and fetch lookup ports are combinational and give identical results for identical addresses.
- R8: Register index 0 is control. Index 2+2i is the base of region i and index 3+2i is its limit. A secure write takes effect at the next clock edge. A secure read returns the stored bits (all other bits zero) in the same cycle. Unmapped indices read as zero.
- R9: A configuration write marked nonsecure changes nothing. A read marked nonsecure returns zero.
- R10: The violation flag goes to 1 one cycle after any nonsecure configuration access. Only reset clears it.
- R11: `core_secure` is registered. One cycle after a cycle with `fetch_valid` high, it equals (fetch attribute == secure). Without `fetch_valid` it holds its value. Reset sets it to 1.
- R12: After reset, the global enable is 0, all regions are disabled and zeroed, and the violation flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_secure | input | 1 | Attribute of the configuration access, 1 = secure |
| cfg_idx | input | 5 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, combinational |
| cfg_violation | output | 1 | Sticky nonsecure-access flag |
| data_addr | input | 32 | Data access address |
| data_attr | output | 2 | Data access attribute |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Fetch address |
| fetch_attr | output | 2 | Fetch attribute |
| core_secure | output | 1 | Processor security state |

## Verification
The default map is tested with the regions set to nonsecure everywhere, on both aliases of each window and on addresses outside the windows. This separates the bit-28 decode from the window decode. The region logic is tested at the first and last 32-byte granule of a region, one granule past each end, inside an overlap, and inside a nonsecure-callable region that lies in a secure alias. These cases separate an inclusive compare from an off-by-one compare, and the overlap rule from the floor rule. Nonsecure writes are followed by secure readback and by lookups. Fetch sequences that alternate between secure and nonsecure code, with the strobe high and then low, show whether the core state updates only on valid fetches.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [1:0] {
    ATTR_NS  = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_S   = 2'b10
  } attr_e;

  localparam int GRAN_LSB = 5;
  localparam int PAGE_W   = 32 - GRAN_LSB;

  typedef struct packed {
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] limit;
    logic              en;
    logic              nsc;
  } region_t;

  // more secure of two attributes
  function automatic attr_e attr_max(attr_e a, attr_e b);
    return (a > b) ? a : b;
  endfunction

  // fixed aliased default map
  function automatic attr_e dflt_attr(logic [31:0] addr);
    if (addr[31:29] <= 3'd2)
      return addr[28] ? ATTR_S : ATTR_NS;
    return ATTR_NS;
  endfunction

  function automatic logic region_hit(logic [31:0] addr, region_t r);
    logic [PAGE_W-1:0] pg;
    pg = addr[31:GRAN_LSB];
    return r.en && (pg >= r.base) && (pg <= r.limit);
  endfunction

endpackage

// File: rtl/sau_cfg_regs.sv
module sau_cfg_regs
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_valid,
  input  logic                         cfg_write,
  input  logic                         cfg_secure,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  output logic                         cfg_violation,
  output logic                         regions_on,
  output region_t [NUM_REGIONS-1:0]    regions
);

  logic sec_wr, ns_acc;
  assign sec_wr = cfg_valid && cfg_write && cfg_secure;
  assign ns_acc = cfg_valid && !cfg_secure;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regions_on    <= 1'b0;
      cfg_violation <= 1'b0;
    end else begin
      if (sec_wr && cfg_idx == '0) regions_on <= cfg_wdata[0];
      if (ns_acc) cfg_violation <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reg
    localparam logic [IDX_W-1:0] BASE_IDX  = IDX_W'(2 + 2 * i);
    localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(3 + 2 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regions[i] <= '0;
      end else if (sec_wr) begin
        if (cfg_idx == BASE_IDX) regions[i].base <= cfg_wdata[31:GRAN_LSB];
        if (cfg_idx == LIMIT_IDX) begin
          regions[i].limit <= cfg_wdata[31:GRAN_LSB];
          regions[i].nsc   <= cfg_wdata[1];
          regions[i].en    <= cfg_wdata[0];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_valid && !cfg_write && cfg_secure) begin
      if (cfg_idx == '0) cfg_rdata = {31'd0, regions_on};
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (cfg_idx == IDX_W'(2 + 2 * i))
          cfg_rdata = {regions[i].base, 5'd0};
        if (cfg_idx == IDX_W'(3 + 2 * i))
          cfg_rdata = {regions[i].limit, 3'd0, regions[i].nsc, regions[i].en};
      end
    end
  end

endmodule

// File: rtl/sau_lookup.sv
module sau_lookup
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8
) (
  input  region_t [NUM_REGIONS-1:0] regions,
  input  logic                      regions_on,
  input  logic [31:0]               addr,
  output attr_e                     attr,
  output attr_e                     dflt,
  output attr_e                     prog
);

  localparam int CNT_W = $clog2(NUM_REGIONS + 1);

  logic [NUM_REGIONS-1:0] hit;
  logic [NUM_REGIONS-1:0] hit_nsc;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_cmp
    assign hit[i]     = region_hit(addr, regions[i]);
    assign hit_nsc[i] = hit[i] && regions[i].nsc;
  end

  logic [CNT_W-1:0] n_hit;
  always_comb begin
    n_hit = '0;
    for (int i = 0; i < NUM_REGIONS; i++) n_hit = n_hit + CNT_W'(hit[i]);
  end

  always_comb begin
    if (!regions_on || n_hit != CNT_W'(1)) prog = ATTR_S;
    else if (|hit_nsc)                      prog = ATTR_NSC;
    else                                    prog = ATTR_NS;
  end

  assign dflt = dflt_attr(addr);
  assign attr = attr_max(prog, dflt);

endmodule

// File: rtl/sec_attr_unit.sv
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W      = $clog2(2 + 2 * NUM_REGIONS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic             cfg_write,
  input  logic             cfg_secure,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_violation,
  input  logic [31:0]      data_addr,
  output logic [1:0]       data_attr,
  input  logic             fetch_valid,
  input  logic [31:0]      fetch_addr,
  output logic [1:0]       fetch_attr,
  output logic             core_secure
);

  region_t [NUM_REGIONS-1:0] regions;
  logic  regions_on;
  attr_e data_res, data_dflt, data_prog;
  attr_e fetch_res, fetch_dflt, fetch_prog;

  sau_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .cfg_valid, .cfg_write, .cfg_secure, .cfg_idx, .cfg_wdata,
    .cfg_rdata, .cfg_violation, .regions_on, .regions
  );

  sau_lookup #(.NUM_REGIONS(NUM_REGIONS)) u_data_lu (
    .regions, .regions_on, .addr(data_addr),
    .attr(data_res), .dflt(data_dflt), .prog(data_prog)
  );

  sau_lookup #(.NUM_REGIONS(NUM_REGIONS)) u_fetch_lu (
    .regions, .regions_on, .addr(fetch_addr),
    .attr(fetch_res), .dflt(fetch_dflt), .prog(fetch_prog)
  );

  assign data_attr  = data_res;
  assign fetch_attr = fetch_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           core_secure <= 1'b1;
    else if (fetch_valid) core_secure <= (fetch_res == ATTR_S);
  end

endmodule

// File: rtl/sau_checker.sv
module sau_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_valid,
  input logic        cfg_secure,
  input logic [31:0] cfg_rdata,
  input logic        cfg_violation,
  input logic        fetch_valid,
  input logic [1:0]  fetch_attr,
  input logic [1:0]  data_attr,
  input logic [1:0]  data_dflt,
  input logic [1:0]  data_prog,
  input logic        regions_on,
  input logic        core_secure
);

  AST_CORE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> core_secure == ($past(fetch_attr) == 2'b10)); // R11
  AST_CORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(core_secure)); // R11
  AST_DEFAULT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    data_attr >= data_dflt); // R6
  AST_PROG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    data_attr >= data_prog); // R6
  AST_GLOBAL_OFF_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    !regions_on |-> data_attr == 2'b10); // R4
  AST_NS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_secure) |-> cfg_rdata == 32'd0); // R9
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_secure) |=> cfg_violation); // R10
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_violation |=> cfg_violation); // R10
  AST_ATTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    data_attr != 2'b11 && fetch_attr != 2'b11); // R1

endmodule

bind sec_attr_unit sau_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_secure(cfg_secure),
  .cfg_rdata(cfg_rdata), .cfg_violation(cfg_violation),
  .fetch_valid(fetch_valid), .fetch_attr(fetch_attr), .data_attr(data_attr),
  .data_dflt(data_dflt), .data_prog(data_prog), .regions_on(regions_on),
  .core_secure(core_secure)
);

// File: tb/tb_sec_attr_unit.sv
`timescale 1ns/1ps
module tb_sec_attr_unit;

  localparam logic [1:0] NS = 2'b00, NSC = 2'b01, S = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_write = 1'b0, cfg_secure = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_violation;
  logic [31:0] data_addr = '0, fetch_addr = '0;
  logic [1:0]  data_attr, fetch_attr;
  logic        fetch_valid = 1'b0;
  logic        core_secure;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sec_attr_unit dut (
    .clk, .rst_n, .cfg_valid, .cfg_write, .cfg_secure, .cfg_idx, .cfg_wdata,
    .cfg_rdata, .cfg_violation, .data_addr, .data_attr, .fetch_valid,
    .fetch_addr, .fetch_attr, .core_secure
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cfg_wr(logic [4:0] idx, logic [31:0] d, logic sec);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_secure = sec;
    cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
  endtask

  task automatic cfg_rd(string req, logic [4:0] idx, logic sec, logic [31:0] exp);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_secure = sec; cfg_idx = idx;
    #1 check(req, cfg_rdata, exp);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] a, logic [1:0] exp);
    data_addr = a; fetch_addr = a;
    #1;
    check(req, {30'd0, data_attr}, {30'd0, exp});
    check(req, {30'd0, fetch_attr}, {30'd0, exp});
  endtask

  task automatic t_reset;
    check("R12 violation", {31'd0, cfg_violation}, 32'd0);
    check("R11 reset state", {31'd0, core_secure}, 32'd1);
    cfg_rd("R12 ctrl", 5'd0, 1'b1, 32'd0);
    cfg_rd("R12 limit0", 5'd3, 1'b1, 32'd0);
    look("R4 off", 32'h0800_0000, S);
  endtask

  task automatic t_default_map;
    cfg_wr(5'd2, 32'h0000_0000, 1'b1);
    cfg_wr(5'd3, 32'hFFFF_FFE1, 1'b1);
    cfg_wr(5'd0, 32'h1, 1'b1);
    cfg_rd("R8 limit readback", 5'd3, 1'b1, 32'hFFFF_FFE1);
    cfg_rd("R8 ctrl readback", 5'd0, 1'b1, 32'h1);
    cfg_rd("R8 unmapped", 5'd1, 1'b1, 32'h0);
    @(negedge clk);
    look("R2 flash ns", 32'h0800_0000, NS);
    look("R2 flash s", 32'h1800_0000, S);
    look("R2 sram ns", 32'h2000_0000, NS);
    look("R2 sram s", 32'h3000_0000, S);
    look("R2 periph ns", 32'h4000_0000, NS);
    look("R2 periph s", 32'h5000_0000, S);
    look("R2 outside", 32'h7000_0000, NS);
    look("R2 outside high", 32'hE000_0000, NS);
    cfg_wr(5'd3, 32'h0, 1'b1);
  endtask

  task automatic t_regions;
    cfg_wr(5'd4, 32'h2000_0000, 1'b1);
    cfg_wr(5'd5, 32'h2000_0003, 1'b1);
    cfg_wr(5'd6, 32'h2000_0100, 1'b1);
    cfg_wr(5'd7, 32'h2000_01E1, 1'b1);
    cfg_rd("R8 base readback", 5'd6, 1'b1, 32'h2000_0100);
    @(negedge clk);
    look("R3 nsc last byte", 32'h2000_001F, NSC);
    look("R5 just past", 32'h2000_0020, S);
    look("R3 ns first", 32'h2000_0100, NS);
    look("R3 ns last", 32'h2000_01FF, NS);
    look("R5 above limit", 32'h2000_0200, S);
    look("R5 below base", 32'h2000_00FF, S);
    cfg_wr(5'd8, 32'h2000_0180, 1'b1);
    cfg_wr(5'd9, 32'h2000_02E1, 1'b1);
    @(negedge clk);
    look("R5 overlap", 32'h2000_0190, S);
    look("R3 r3 single", 32'h2000_0250, NS);
    cfg_wr(5'd10, 32'h3000_0400, 1'b1);
    cfg_wr(5'd11, 32'h3000_04E3, 1'b1);
    @(negedge clk);
    look("R6 floor", 32'h3000_0400, S);
    data_addr = 32'h2000_0000; fetch_addr = 32'h2000_0100;
    #1 check("R7 independent ports", {data_attr, fetch_attr}, {NSC, NS});
  endtask

  task automatic t_ns_access;
    cfg_wr(5'd0, 32'h0, 1'b0);
    check("R10 set", {31'd0, cfg_violation}, 32'd1);
    cfg_rd("R9 ctrl kept", 5'd0, 1'b1, 32'h1);
    cfg_wr(5'd7, 32'h0, 1'b0);
    look("R9 region kept", 32'h2000_0100, NS);
    cfg_rd("R9 ns read zero", 5'd7, 1'b0, 32'h0);
    cfg_wr(5'd0, 32'h1, 1'b1);
    check("R10 sticky", {31'd0, cfg_violation}, 32'd1);
  endtask

  task automatic t_core_state;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 32'h2000_0100;
    @(negedge clk);
    check("R11 enter ns", {31'd0, core_secure}, 32'd0);
    fetch_valid = 1'b0; fetch_addr = 32'h1800_0000;
    @(negedge clk);
    check("R11 hold", {31'd0, core_secure}, 32'd0);
    fetch_valid = 1'b1;
    @(negedge clk);
    check("R11 enter s", {31'd0, core_secure}, 32'd1);
    fetch_addr = 32'h2000_0000;
    @(negedge clk);
    check("R11 nsc is not secure", {31'd0, core_secure}, 32'd0);
    fetch_valid = 1'b0;
  endtask

  task automatic t_global_off;
    cfg_wr(5'd0, 32'h0, 1'b1);
    look("R4 disabled", 32'h2000_0100, S);
    look("R4 disabled nsc", 32'h2000_0000, S);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_map();
    t_regions();
    t_ns_access();
    t_core_state();
    t_global_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule